// File: doc/BRIEF.md
# Two-Way Write-Back Byte Data Cache

This block is a byte-wide data cache for a 16-bit byte address space. The CPU side issues one byte load or store at a time with a valid/ready handshake and gets back a single-cycle response pulse. The memory side moves whole 16-byte lines through a request/acknowledge port. It uses that port to fetch lines on a miss and to copy dirty lines back before they are replaced.

The cache holds 16 sets of two ways. Each line has its own valid bit, dirty bit and tag, and each set keeps one bit naming its most recently used way. Stores that hit change only the cached byte and mark the line dirty. Stores that miss allocate the line first. On a miss an empty way is filled if the set has one. Otherwise a pseudo-random pick is steered away from the most recently used way. With two ways, this always replaces the way that was not used last.

Top module: `dcache_wb`

## Requirements
- R1: An address is split as tag = bits 15:8, set index = bits 7:4 and byte offset = bits 3:0. There are 16 sets of 2 ways, and each way holds a 16-byte line.
- R2: After reset, req_ready_o is 1, mem_req_o is 0 and rsp_valid_o is 0, and every line is invalid. Any first access to a line therefore issues a fill, including an access that hit before the reset.
- R3: A request is taken when req_valid_i and req_ready_o are both 1. Each request produces exactly one rsp_valid_o pulse, one cycle wide. req_ready_o stays 0 while the request is in progress. On a store, rsp_rdata_o returns the stored byte.
- R4: A load hit returns the cached byte with no memory request. rsp_valid_o is 1 in the cycle after the second rising edge following acceptance.
- R5: A store hit changes only the addressed byte and sets the line dirty. No memory write happens at that time.
- R6: A miss issues a read request (mem_we_o = 0) at the line-aligned address {tag, set, 4'h0}. The request is held steady until mem_ack_i. The returned line is installed and the requested byte is returned.
- R7: Before the new line is fetched, a dirty victim is written back (mem_we_o = 1) with its own line address and all 128 bits of its data. A clean victim causes no write-back.
- R8: If the indexed set has an invalid way, a miss fills that way (the lowest-numbered invalid way) and evicts nothing.
- R9: When both ways are valid, the victim is never the most recently used way. The MRU bit is updated on every hit and on every fill.
- R10: A store miss allocates the line (fill), merges the byte and marks the line dirty.
- R11: Byte k of a line travels on bits 8k+7:8k of mem_rdata_i and mem_wdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request valid |
| req_ready_o | output | 1 | Cache can accept a request |
| req_we_i | input | 1 | 1 = byte store, 0 = byte load |
| req_addr_i | input | 16 | Byte address |
| req_wdata_i | input | 8 | Store data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | 8 | Load data, or the stored byte on a store |
| mem_req_o | output | 1 | Memory line request |
| mem_we_o | output | 1 | 1 = write-back, 0 = fill |
| mem_addr_o | output | 16 | Line-aligned memory address |
| mem_wdata_o | output | 128 | Write-back line data |
| mem_ack_i | input | 1 | Memory completes the current request |
| mem_rdata_i | input | 128 | Fill line data |

## Verification
The hardest case to reach is a miss into a full set whose victim is dirty and is not the most recently used way. Reaching it takes a cold fill, a fill of the second way, a store that dirties one line, and then a hit on the other way so that the MRU bit points away from the dirty line. The stimulus table builds this order in set 0xC and again in set 0x2, where the dirty line comes from a store miss. The bench then checks the write-back address and the byte lanes against a line pattern computed from the address. Earlier steps in the same set check that an empty way is filled first and that the MRU line survives an eviction.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL
  } dc_state_e;
endpackage

// File: rtl/dcache_lfsr.sv
module dcache_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] lfsr_q;
  logic         fb;

  // taps 16,14,13,11
  assign fb = lfsr_q[W-1] ^ lfsr_q[W-3] ^ lfsr_q[W-4] ^ lfsr_q[W-6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[W-2:0], fb};
  end

  assign rnd_o = lfsr_q;
endmodule

// File: rtl/dcache_tag_match.sv
module dcache_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) way_o = WAY_W'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/dcache_victim.sv
module dcache_victim #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] mru_i,
  input  logic [WAY_W-1:0] rnd_i,
  output logic [WAY_W-1:0] way_o
);
  // WAYS is a power of two >= 2, so +1 wraps inside the set
  always_comb begin
    way_o = rnd_i;
    if (way_o == mru_i) way_o = way_o + 1'b1;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) way_o = WAY_W'(i);
    end
  end
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb #(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 4,
  parameter int OFF_W  = 4,
  parameter int WAYS   = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic                         req_we_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [7:0]                   req_wdata_i,
  output logic                         rsp_valid_o,
  output logic [7:0]                   rsp_rdata_o,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic [8*(1<<OFF_W)-1:0]      mem_wdata_o,
  input  logic                         mem_ack_i,
  input  logic [8*(1<<OFF_W)-1:0]      mem_rdata_i
);
  import dcache_pkg::*;

  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int SETS   = 1 << SET_W;
  localparam int LINE_W = 8 * (1 << OFF_W);
  localparam int WAY_W  = $clog2(WAYS);

  dc_state_e          state_q;
  logic               we_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         wdata_q;
  logic [WAY_W-1:0]   victim_q;
  logic               rsp_valid_q;
  logic [7:0]         rsp_data_q;

  logic [WAYS-1:0]               valid_q [SETS];
  logic [WAYS-1:0]               dirty_q [SETS];
  logic [WAY_W-1:0]              mru_q   [SETS];
  logic [WAYS-1:0][TAG_W-1:0]    tag_q   [SETS];
  logic [WAYS-1:0][LINE_W-1:0]   data_q  [SETS];

  logic [TAG_W-1:0]  req_tag;
  logic [SET_W-1:0]  req_set;
  logic [OFF_W-1:0]  req_off;
  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  vic_way;
  logic [15:0]       rnd;

  assign req_tag = addr_q[ADDR_W-1 -: TAG_W];
  assign req_set = addr_q[OFF_W +: SET_W];
  assign req_off = addr_q[OFF_W-1:0];

  dcache_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rnd_o  (rnd)
  );

  dcache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .valid_i (valid_q[req_set]),
    .tags_i  (tag_q[req_set]),
    .tag_i   (req_tag),
    .hit_o   (hit),
    .way_o   (hit_way)
  );

  dcache_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid_i (valid_q[req_set]),
    .mru_i   (mru_q[req_set]),
    .rnd_i   (rnd[WAY_W-1:0]),
    .way_o   (vic_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      we_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      victim_q    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        mru_q[s]   <= '0;
      end
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          we_q    <= req_we_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: if (hit) begin
          mru_q[req_set] <= hit_way;
          rsp_valid_q    <= 1'b1;
          if (we_q) begin
            dirty_q[req_set][hit_way] <= 1'b1;
            rsp_data_q <= wdata_q;
          end else begin
            rsp_data_q <= data_q[req_set][hit_way][{req_off, 3'b000} +: 8];
          end
          state_q <= ST_IDLE;
        end else begin
          victim_q <= vic_way;
          state_q  <= (valid_q[req_set][vic_way] && dirty_q[req_set][vic_way])
                      ? ST_WB : ST_FILL;
        end
        ST_WB: if (mem_ack_i) begin
          dirty_q[req_set][victim_q] <= 1'b0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (mem_ack_i) begin
          valid_q[req_set][victim_q] <= 1'b1;
          dirty_q[req_set][victim_q] <= 1'b0;
          mru_q[req_set]             <= victim_q;
          state_q <= ST_LOOKUP;  // replay as a hit
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // line storage: no reset needed, guarded by valid bits
  always_ff @(posedge clk_i) begin
    if (state_q == ST_LOOKUP && hit && we_q)
      data_q[req_set][hit_way][{req_off, 3'b000} +: 8] <= wdata_q;
    if (state_q == ST_FILL && mem_ack_i) begin
      data_q[req_set][victim_q] <= mem_rdata_i;
      tag_q[req_set][victim_q]  <= req_tag;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;
  assign mem_req_o   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB)
                       ? {tag_q[req_set][victim_q], req_set, {OFF_W{1'b0}}}
                       : {req_tag, req_set, {OFF_W{1'b0}}};
  assign mem_wdata_o = data_q[req_set][victim_q];
endmodule

// File: rtl/dcache_chk.sv
module dcache_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_ready_o,
  input logic                    rsp_valid_o,
  input logic                    mem_req_o,
  input logic                    mem_we_o,
  input logic [ADDR_W-1:0]       mem_addr_o,
  input logic [8*(1<<OFF_W)-1:0] mem_wdata_o,
  input logic                    mem_ack_i
);
  AST_FILL_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> mem_req_o && !mem_we_o); // R7

  AST_WB_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_ack_i |=> $stable(mem_wdata_o)); // R7

  AST_LINE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[OFF_W-1:0] == '0); // R6

  AST_MEM_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R6

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R3

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o); // R3
endmodule

bind dcache_wb dcache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/dcache_wb_tb.sv
module dcache_wb_tb;
  localparam time CLK_P = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic         req_we_i = 1'b0;
  logic [15:0]  req_addr_i = '0;
  logic [7:0]   req_wdata_i = '0;
  logic         rsp_valid_o;
  logic [7:0]   rsp_rdata_o;
  logic         mem_req_o;
  logic         mem_we_o;
  logic [15:0]  mem_addr_o;
  logic [127:0] mem_wdata_o;
  logic         mem_ack_i;
  logic [127:0] mem_rdata_i;

  int n_chk = 0;
  int n_fail = 0;
  int fill_cnt = 0;
  int wb_cnt = 0;
  logic [15:0]  first_fill_addr = '0;
  logic [15:0]  first_wb_addr = '0;
  logic [127:0] first_wb_data = '0;
  logic [15:0]  last_wb_addr = '0;
  logic [127:0] last_wb_data = '0;
  bit busy_ready_seen = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  dcache_wb u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_we_i(req_we_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: acks the second negedge of a request, byte k on bits 8k+:8 (R11)
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
        wait_cnt = 0;
      end else if (mem_req_o) begin
        wait_cnt++;
        if (wait_cnt == 2) begin
          mem_ack_i = 1'b1;
          if (mem_we_o) begin
            wb_cnt++;
            if (wb_cnt == 1) begin
              first_wb_addr = mem_addr_o;
              first_wb_data = mem_wdata_o;
            end
            last_wb_addr = mem_addr_o;
            last_wb_data = mem_wdata_o;
          end else begin
            fill_cnt++;
            if (fill_cnt == 1) first_fill_addr = mem_addr_o;
            for (int k = 0; k < 16; k++)
              mem_rdata_i[8*k +: 8] = pat({mem_addr_o[15:4], 4'(k)});
          end
        end
      end
    end
  end

  task automatic access(input logic we, input logic [15:0] addr, input logic [7:0] wd,
                        output logic [7:0] rd, output int lat);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_we_i    = we;
    req_addr_i  = addr;
    req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (req_ready_o) busy_ready_seen = 1;
    lat = 1;
    while (!rsp_valid_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
    rd = rsp_rdata_o;
  endtask

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        use_pat;
    logic [7:0]  exp;
    logic [1:0]  fills;
    logic [1:0]  wbs;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h7ACE, 8'h00, 1'b1, 8'h00, 2'd1, 2'd0, 4'd6},  // R6 cold miss, set C way0
    '{1'b0, 16'h7AC0, 8'h00, 1'b1, 8'h00, 2'd0, 2'd0, 4'd4},  // R4 hit
    '{1'b0, 16'h3BC4, 8'h00, 1'b1, 8'h00, 2'd1, 2'd0, 4'd8},  // R8 empty way1 filled
    '{1'b0, 16'h7AC1, 8'h00, 1'b1, 8'h00, 2'd0, 2'd0, 4'd8},  // R8 way0 kept
    '{1'b0, 16'h5DC2, 8'h00, 1'b1, 8'h00, 2'd1, 2'd0, 4'd9},  // R9 evicts non-MRU 3B
    '{1'b0, 16'h7AC3, 8'h00, 1'b1, 8'h00, 2'd0, 2'd0, 4'd9},  // R9 MRU line kept
    '{1'b0, 16'h3BC5, 8'h00, 1'b1, 8'h00, 2'd1, 2'd0, 4'd9},  // R9 3B was evicted
    '{1'b1, 16'h3BC5, 8'hA5, 1'b0, 8'hA5, 2'd0, 2'd0, 4'd5},  // R5 store hit
    '{1'b0, 16'h3BC5, 8'h00, 1'b0, 8'hA5, 2'd0, 2'd0, 4'd5},  // R5 byte updated
    '{1'b0, 16'h3BC6, 8'h00, 1'b1, 8'h00, 2'd0, 2'd0, 4'd5},  // R5 neighbour unchanged
    '{1'b0, 16'h7AC7, 8'h00, 1'b1, 8'h00, 2'd0, 2'd0, 4'd4},  // R4 hit, MRU -> 7A
    '{1'b0, 16'h11C0, 8'h00, 1'b1, 8'h00, 2'd1, 2'd1, 4'd7},  // R7 dirty 3B written back
    '{1'b1, 16'h2023, 8'h3C, 1'b0, 8'h3C, 2'd1, 2'd0, 4'd10}, // R10 store miss allocates
    '{1'b0, 16'h2023, 8'h00, 1'b0, 8'h3C, 2'd0, 2'd0, 4'd10}, // R10 merged byte
    '{1'b0, 16'h2024, 8'h00, 1'b1, 8'h00, 2'd0, 2'd0, 4'd10}, // R10 rest of line from fill
    '{1'b0, 16'h4420, 8'h00, 1'b1, 8'h00, 2'd1, 2'd0, 4'd8},  // R8 empty way filled
    '{1'b0, 16'h9920, 8'h00, 1'b1, 8'h00, 2'd1, 2'd1, 4'd7}   // R7 dirty 20 written back
  };

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lat;
    int f0;
    int w0;
    logic [7:0] exp;

    repeat (3) @(negedge clk_i);
    // R2 reset state
    chk(req_ready_o == 1'b1, "R2 ready after reset", 128'(req_ready_o), 128'd1);
    chk(mem_req_o == 1'b0, "R2 no mem request in reset", 128'(mem_req_o), 128'd0);
    chk(rsp_valid_o == 1'b0, "R2 no response in reset", 128'(rsp_valid_o), 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1 && mem_req_o == 1'b0, "R2 idle after release",
        128'({req_ready_o, mem_req_o}), 128'b10);

    for (int i = 0; i < NV; i++) begin
      f0 = fill_cnt;
      w0 = wb_cnt;
      access(VECS[i].we, VECS[i].addr, VECS[i].wd, rd, lat);
      exp = VECS[i].use_pat ? pat(VECS[i].addr) : VECS[i].exp;
      chk(rd == exp, $sformatf("R%0d vec %0d data", VECS[i].req, i), 128'(rd), 128'(exp));
      chk(fill_cnt - f0 == int'(VECS[i].fills), $sformatf("R%0d vec %0d fills", VECS[i].req, i),
          128'(fill_cnt - f0), 128'(VECS[i].fills));
      chk(wb_cnt - w0 == int'(VECS[i].wbs), $sformatf("R%0d vec %0d write-backs", VECS[i].req, i),
          128'(wb_cnt - w0), 128'(VECS[i].wbs));
      if (VECS[i].fills == 2'd0)
        chk(lat == 2, $sformatf("R4 vec %0d hit latency", i), 128'(lat), 128'd2);
    end

    // R1 R6 fill address of first miss 0x7ACE is line-aligned {7A, C, 0}
    chk(first_fill_addr == 16'h7AC0, "R1 first fill address", 128'(first_fill_addr), 128'h7AC0);
    // R7 first write-back: line 3B/C with stored byte at offset 5
    chk(first_wb_addr == 16'h3BC0, "R7 write-back address", 128'(first_wb_addr), 128'h3BC0);
    chk(first_wb_data[8*5 +: 8] == 8'hA5, "R11 write-back byte lane 5",
        128'(first_wb_data[8*5 +: 8]), 128'hA5);
    chk(first_wb_data[8*6 +: 8] == pat(16'h3BC6), "R5 untouched byte in write-back",
        128'(first_wb_data[8*6 +: 8]), 128'(pat(16'h3BC6)));
    // R10 store-miss line written back with merged byte at offset 3
    chk(last_wb_addr == 16'h2020, "R10 allocated line written back", 128'(last_wb_addr), 128'h2020);
    chk(last_wb_data[8*3 +: 8] == 8'h3C, "R10 merged byte in write-back",
        128'(last_wb_data[8*3 +: 8]), 128'h3C);
    chk(last_wb_data[8*4 +: 8] == pat(16'h2024), "R11 write-back byte lane 4",
        128'(last_wb_data[8*4 +: 8]), 128'(pat(16'h2024)));
    chk(!busy_ready_seen, "R3 ready low while busy", 128'(busy_ready_seen), 128'd0);

    // R2 reset invalidates lines: 0x7AC0 was a hit, must miss now
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(req_ready_o && !mem_req_o && !rsp_valid_o, "R2 outputs during second reset",
        128'({req_ready_o, mem_req_o, rsp_valid_o}), 128'b100);
    rst_ni = 1'b1;
    f0 = fill_cnt;
    access(1'b0, 16'h7AC0, 8'h00, rd, lat);
    chk(fill_cnt - f0 == 1, "R2 cold miss after reset", 128'(fill_cnt - f0), 128'd1);
    chk(rd == pat(16'h7AC0), "R6 data after refill", 128'(rd), 128'(pat(16'h7AC0)));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule